// File: doc/BRIEF.md
# Prioritized Processor Interrupt Selector

This block picks the interrupt class a processor takes next. It holds the pending state of every asynchronous source: small stacks of machine-check and external requests, a clock-comparator request, a CPU-timer request and one request stack per I/O subclass. It gates each class with the enable bits of the current status-word mask and of two control registers. Its combinational outputs preview the chosen class and its interruption code. When the core pulses `take_i`, the chosen request is consumed on that clock edge.

A synchronous program or supervisor-call exception that is already in progress overrides every asynchronous source. The block also produces the old status-word mask with the condition code merged in. It records a halt when a newly loaded status word requests a wait state with all interrupt classes disabled. Saving state to memory and executing instructions are left to the surrounding core.

Top module: `irq_sel`

## Requirements
- R1: After reset every stack is empty, the timer flags are clear, `irq_o` and `halted_o` are 0, and `sel_class_o` is NONE (0).
- R2: While `sync_valid_i` is high, `sel_class_o` is SVC (2) if `sync_svc_i` is set and PGM (1) otherwise, and `int_code_o` equals `sync_code_i`. A take in this state consumes no asynchronous request.
- R3: The asynchronous classes are ranked machine check (3), then external (4), then I/O (5). Each class is eligible only when its status-mask bit is set: bit 50 for machine check, bit 56 for external and bit 57 for I/O.
- R4: A machine check is eligible only while `cr14_crw_en_i` is 1. Otherwise it stays pending and selection falls through to the lower classes.
- R5: Within the external class, a stacked external request comes first, then the clock-comparator request (code 0x1004), then the CPU-timer request (code 0x1005). A take clears only the source that was delivered. A new request arriving in the same cycle as that clear wins.
- R6: The machine-check and external stacks deliver the most recently pushed entry first. A push into a full stack with no pop in the same cycle is dropped. A push together with a pop replaces the top entry. Each class's pending flag drops once its stack is empty.
- R7: The I/O class delivers from the lowest-numbered subclass whose stack is non-empty and whose bit in `cr6_isc_en_i` is set. `int_code_o` carries the subclass number, `io_word_o` carries that stack's top entry, and one take pops exactly one entry.
- R8: `pend_io_o` stays high while any subclass stack holds an entry, whether that subclass is masked or not.
- R9: `old_mask_o` equals `psw_mask_i` with bits 45:44 replaced by `cc_i`.
- R10: On `load_psw_i`, `halted_o` becomes 1 if `new_mask_i` has wait bit 49 set and bits 50, 56 and 57 all clear. Otherwise it becomes 0.
- R11: `irq_o` is high exactly when any machine-check, external, clock-comparator, CPU-timer or I/O request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| psw_mask_i | input | 64 | Current status-word mask |
| cc_i | input | 2 | Current condition code |
| cr6_isc_en_i | input | NUM_ISC | Per-subclass I/O enables |
| cr14_crw_en_i | input | 1 | Channel-report machine-check enable |
| sync_valid_i | input | 1 | Synchronous exception in progress |
| sync_svc_i | input | 1 | The exception is a supervisor call |
| sync_code_i | input | CODE_W | Code of the synchronous exception |
| mchk_push_i | input | 1 | Push a machine-check request |
| mchk_code_i | input | CODE_W | Machine-check code |
| ext_push_i | input | 1 | Push an external request |
| ext_code_i | input | CODE_W | External interruption code |
| tod_req_i | input | 1 | Set the clock-comparator request |
| cpt_req_i | input | 1 | Set the CPU-timer request |
| io_push_i | input | 1 | Push an I/O request |
| io_isc_i | input | ISC_W | Subclass of the pushed I/O request |
| io_word_i | input | IO_W | I/O interruption word |
| take_i | input | 1 | Commit the current selection |
| load_psw_i | input | 1 | A new status word is loaded |
| new_mask_i | input | 64 | Mask of the new status word |
| sel_class_o | output | 3 | Selected class: 0 none, 1 PGM, 2 SVC, 3 MCHK, 4 EXT, 5 IO |
| int_code_o | output | CODE_W | Interruption code of the selection |
| io_word_o | output | IO_W | I/O word when the class is IO, else 0 |
| old_mask_o | output | 64 | Mask to save, with the condition code merged |
| pend_mchk_o | output | 1 | Machine-check stack non-empty |
| pend_ext_o | output | 1 | External stack non-empty |
| pend_tod_o | output | 1 | Clock-comparator request pending |
| pend_cpt_o | output | 1 | CPU-timer request pending |
| pend_io_o | output | 1 | Any I/O stack non-empty |
| irq_o | output | 1 | Any asynchronous request pending |
| halted_o | output | 1 | Processor halted by the last status load |

## Verification
Directed sequences come first. External pushes are mixed with both timer requests, which separates stack order from timer order and shows that a take clears only the consumed timer. A machine check is held with its control-register enable off while an external request waits, which tells a fall-through apart from a blocked selection. A stack is overfilled to show that the extra push is dropped. An I/O subclass is masked while another is open, which checks subclass order and that the pending flag survives masked entries. Random traffic with random mask bits, pushes, takes and synchronous exceptions then compares every output each cycle against a model kept in the bench.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;
  typedef enum logic [2:0] {
    CLS_NONE = 3'd0,
    CLS_PGM  = 3'd1,
    CLS_SVC  = 3'd2,
    CLS_MCHK = 3'd3,
    CLS_EXT  = 3'd4,
    CLS_IO   = 3'd5
  } irq_cls_e;

  localparam int BIT_WAIT = 49;
  localparam int BIT_MCHK = 50;
  localparam int BIT_EXT  = 56;
  localparam int BIT_IO   = 57;
  localparam int CC_LO    = 44;

  localparam logic [15:0] TOD_CODE = 16'h1004;
  localparam logic [15:0] CPT_CODE = 16'h1005;
endpackage

// File: rtl/irq_lifo.sv
module irq_lifo #(
  parameter int DEPTH = 4,
  parameter int W     = 16,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] top_o,
  output logic         nonempty_o
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] base;
  logic             pop_ok, push_ok;

  always_comb begin
    pop_ok  = pop_i && (cnt_q != '0);
    base    = cnt_q - CNT_W'(pop_ok);
    push_ok = push_i && (base < CNT_W'(DEPTH));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= base + CNT_W'(push_ok);
  end

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[PTR_W'(base)] <= data_i;
  end

  assign nonempty_o = (cnt_q != '0);
  assign top_o      = nonempty_o ? mem_q[PTR_W'(cnt_q - CNT_W'(1))] : '0;
endmodule

// File: rtl/irq_io_bank.sv
module irq_io_bank #(
  parameter int NUM_ISC  = 8,
  parameter int IO_DEPTH = 2,
  parameter int IO_W     = 32,
  localparam int ISC_W = $clog2(NUM_ISC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               push_i,
  input  logic [ISC_W-1:0]   isc_i,
  input  logic [IO_W-1:0]    word_i,
  input  logic [NUM_ISC-1:0] isc_en_i,
  input  logic               pop_i,
  output logic               deliv_o,
  output logic [ISC_W-1:0]   pick_o,
  output logic [IO_W-1:0]    word_o,
  output logic               any_o
);
  logic [NUM_ISC-1:0] ne;
  logic [IO_W-1:0]    tops [NUM_ISC];
  logic [NUM_ISC-1:0] deliv;

  for (genvar g = 0; g < NUM_ISC; g++) begin : g_isc
    irq_lifo #(.DEPTH(IO_DEPTH), .W(IO_W)) u_q (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .push_i     (push_i && (isc_i == ISC_W'(g))),
      .data_i     (word_i),
      .pop_i      (pop_i && deliv_o && (pick_o == ISC_W'(g))),
      .top_o      (tops[g]),
      .nonempty_o (ne[g])
    );
    assign deliv[g] = ne[g] & isc_en_i[g];
  end

  // lowest deliverable subclass wins
  always_comb begin
    pick_o = '0;
    for (int i = NUM_ISC - 1; i >= 0; i--) begin
      if (deliv[i]) pick_o = ISC_W'(i);
    end
  end

  assign deliv_o = |deliv;
  assign any_o   = |ne;
  assign word_o  = tops[pick_o];
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_sel_pkg::*;
#(
  parameter int CODE_W = 16,
  parameter int ISC_W  = 3
) (
  input  logic              take_i,
  input  logic [63:0]       psw_mask_i,
  input  logic              cr14_crw_en_i,
  input  logic              sync_valid_i,
  input  logic              sync_svc_i,
  input  logic [CODE_W-1:0] sync_code_i,
  input  logic              mchk_ne_i,
  input  logic [CODE_W-1:0] mchk_top_i,
  input  logic              ext_ne_i,
  input  logic [CODE_W-1:0] ext_top_i,
  input  logic              tod_i,
  input  logic              cpt_i,
  input  logic              io_deliv_i,
  input  logic [ISC_W-1:0]  io_pick_i,
  output irq_cls_e          cls_o,
  output logic [CODE_W-1:0] code_o,
  output logic              pop_mchk_o,
  output logic              pop_ext_o,
  output logic              pop_io_o,
  output logic              clr_tod_o,
  output logic              clr_cpt_o
);
  always_comb begin
    cls_o      = CLS_NONE;
    code_o     = '0;
    pop_mchk_o = 1'b0;
    pop_ext_o  = 1'b0;
    pop_io_o   = 1'b0;
    clr_tod_o  = 1'b0;
    clr_cpt_o  = 1'b0;
    if (sync_valid_i) begin
      cls_o  = sync_svc_i ? CLS_SVC : CLS_PGM;
      code_o = sync_code_i;
    end else if (psw_mask_i[BIT_MCHK] && cr14_crw_en_i && mchk_ne_i) begin
      cls_o      = CLS_MCHK;
      code_o     = mchk_top_i;
      pop_mchk_o = take_i;
    end else if (psw_mask_i[BIT_EXT] && (ext_ne_i || tod_i || cpt_i)) begin
      cls_o = CLS_EXT;
      if (ext_ne_i) begin
        code_o    = ext_top_i;
        pop_ext_o = take_i;
      end else if (tod_i) begin
        code_o    = CODE_W'(TOD_CODE);
        clr_tod_o = take_i;
      end else begin
        code_o    = CODE_W'(CPT_CODE);
        clr_cpt_o = take_i;
      end
    end else if (psw_mask_i[BIT_IO] && io_deliv_i) begin
      cls_o    = CLS_IO;
      code_o   = CODE_W'(io_pick_i);
      pop_io_o = take_i;
    end
  end
endmodule

// File: rtl/irq_sel.sv
module irq_sel
  import irq_sel_pkg::*;
#(
  parameter int NUM_ISC    = 8,
  parameter int CODE_W     = 16,
  parameter int IO_W       = 32,
  parameter int EXT_DEPTH  = 4,
  parameter int MCHK_DEPTH = 2,
  parameter int IO_DEPTH   = 2,
  localparam int ISC_W = $clog2(NUM_ISC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [63:0]        psw_mask_i,
  input  logic [1:0]         cc_i,
  input  logic [NUM_ISC-1:0] cr6_isc_en_i,
  input  logic               cr14_crw_en_i,
  input  logic               sync_valid_i,
  input  logic               sync_svc_i,
  input  logic [CODE_W-1:0]  sync_code_i,
  input  logic               mchk_push_i,
  input  logic [CODE_W-1:0]  mchk_code_i,
  input  logic               ext_push_i,
  input  logic [CODE_W-1:0]  ext_code_i,
  input  logic               tod_req_i,
  input  logic               cpt_req_i,
  input  logic               io_push_i,
  input  logic [ISC_W-1:0]   io_isc_i,
  input  logic [IO_W-1:0]    io_word_i,
  input  logic               take_i,
  input  logic               load_psw_i,
  input  logic [63:0]        new_mask_i,
  output logic [2:0]         sel_class_o,
  output logic [CODE_W-1:0]  int_code_o,
  output logic [IO_W-1:0]    io_word_o,
  output logic [63:0]        old_mask_o,
  output logic               pend_mchk_o,
  output logic               pend_ext_o,
  output logic               pend_tod_o,
  output logic               pend_cpt_o,
  output logic               pend_io_o,
  output logic               irq_o,
  output logic               halted_o
);
  logic [CODE_W-1:0] mchk_top, ext_top;
  logic              io_deliv;
  logic [ISC_W-1:0]  io_pick;
  logic [IO_W-1:0]   io_top;
  logic              pop_mchk, pop_ext, pop_io, clr_tod, clr_cpt;
  logic              tod_q, cpt_q, halt_q;
  irq_cls_e          cls;

  irq_lifo #(.DEPTH(MCHK_DEPTH), .W(CODE_W)) u_mchk (
    .clk_i(clk_i), .rst_ni(rst_ni), .push_i(mchk_push_i), .data_i(mchk_code_i),
    .pop_i(pop_mchk), .top_o(mchk_top), .nonempty_o(pend_mchk_o)
  );

  irq_lifo #(.DEPTH(EXT_DEPTH), .W(CODE_W)) u_ext (
    .clk_i(clk_i), .rst_ni(rst_ni), .push_i(ext_push_i), .data_i(ext_code_i),
    .pop_i(pop_ext), .top_o(ext_top), .nonempty_o(pend_ext_o)
  );

  irq_io_bank #(.NUM_ISC(NUM_ISC), .IO_DEPTH(IO_DEPTH), .IO_W(IO_W)) u_io (
    .clk_i(clk_i), .rst_ni(rst_ni), .push_i(io_push_i), .isc_i(io_isc_i),
    .word_i(io_word_i), .isc_en_i(cr6_isc_en_i), .pop_i(pop_io),
    .deliv_o(io_deliv), .pick_o(io_pick), .word_o(io_top), .any_o(pend_io_o)
  );

  irq_arbiter #(.CODE_W(CODE_W), .ISC_W(ISC_W)) u_arb (
    .take_i(take_i), .psw_mask_i(psw_mask_i), .cr14_crw_en_i(cr14_crw_en_i),
    .sync_valid_i(sync_valid_i), .sync_svc_i(sync_svc_i), .sync_code_i(sync_code_i),
    .mchk_ne_i(pend_mchk_o), .mchk_top_i(mchk_top),
    .ext_ne_i(pend_ext_o), .ext_top_i(ext_top),
    .tod_i(tod_q), .cpt_i(cpt_q),
    .io_deliv_i(io_deliv), .io_pick_i(io_pick),
    .cls_o(cls), .code_o(int_code_o),
    .pop_mchk_o(pop_mchk), .pop_ext_o(pop_ext), .pop_io_o(pop_io),
    .clr_tod_o(clr_tod), .clr_cpt_o(clr_cpt)
  );

  // new request beats same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tod_q  <= 1'b0;
      cpt_q  <= 1'b0;
      halt_q <= 1'b0;
    end else begin
      tod_q <= tod_req_i | (tod_q & ~clr_tod);
      cpt_q <= cpt_req_i | (cpt_q & ~clr_cpt);
      if (load_psw_i)
        halt_q <= new_mask_i[BIT_WAIT] & ~new_mask_i[BIT_MCHK] &
                  ~new_mask_i[BIT_EXT] & ~new_mask_i[BIT_IO];
    end
  end

  assign sel_class_o = cls;
  assign io_word_o   = (cls == CLS_IO) ? io_top : '0;
  assign old_mask_o  = {psw_mask_i[63:CC_LO+2], cc_i, psw_mask_i[CC_LO-1:0]};
  assign pend_tod_o  = tod_q;
  assign pend_cpt_o  = cpt_q;
  assign irq_o       = pend_mchk_o | pend_ext_o | tod_q | cpt_q | pend_io_o;
  assign halted_o    = halt_q;
endmodule

// File: rtl/irq_sel_chk.sv
module irq_sel_chk
  import irq_sel_pkg::*;
#(
  parameter int CODE_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [63:0]       psw_mask_i,
  input logic              cr14_crw_en_i,
  input logic              sync_valid_i,
  input logic              take_i,
  input logic              tod_req_i,
  input logic [2:0]        sel_class_o,
  input logic [CODE_W-1:0] int_code_o,
  input logic              pend_io_o,
  input logic              pend_tod_o,
  input logic              irq_o
);
  a_r2_sync_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_valid_i |-> (sel_class_o == CLS_PGM || sel_class_o == CLS_SVC));

  a_r4_mchk_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_class_o == CLS_MCHK) |-> (cr14_crw_en_i && psw_mask_i[BIT_MCHK]));

  a_r3_ext_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_class_o == CLS_EXT) |-> psw_mask_i[BIT_EXT]);

  a_r3_io_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_class_o == CLS_IO) |-> psw_mask_i[BIT_IO]);

  a_r8_io_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_class_o == CLS_IO) |-> pend_io_o);

  a_r11_idle_none: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> (sel_class_o <= CLS_SVC));

  a_r5_tod_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && sel_class_o == CLS_EXT && int_code_o == CODE_W'(TOD_CODE) &&
     !tod_req_i && !$isunknown(int_code_o)) |=> !pend_tod_o);
endmodule

bind irq_sel irq_sel_chk #(.CODE_W(CODE_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .psw_mask_i(psw_mask_i),
  .cr14_crw_en_i(cr14_crw_en_i), .sync_valid_i(sync_valid_i), .take_i(take_i),
  .tod_req_i(tod_req_i), .sel_class_o(sel_class_o), .int_code_o(int_code_o),
  .pend_io_o(pend_io_o), .pend_tod_o(pend_tod_o), .irq_o(irq_o)
);

// File: tb/irq_sel_tb_top.sv
`timescale 1ns/1ps
module irq_sel_tb_top;
  localparam int NI = 8, CW = 16, IW = 32, ED = 4, MD = 2, QD = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [63:0] psw = '0, nmask = '0;
  logic [1:0]  cc = '0;
  logic [NI-1:0] cr6 = '0;
  logic cr14 = 1'b0, sv = 1'b0, ssvc = 1'b0, mpush = 1'b0, epush = 1'b0;
  logic tod = 1'b0, cpt = 1'b0, ipush = 1'b0, take = 1'b0, lpsw = 1'b0;
  logic [CW-1:0] scode = '0, mcode = '0, ecode = '0;
  logic [2:0] isc = '0;
  logic [IW-1:0] iword = '0;
  logic [2:0] cls_o;
  logic [CW-1:0] code_o;
  logic [IW-1:0] word_o;
  logic [63:0] old_o;
  logic pm_o, pe_o, pt_o, pc_o, pi_o, irq_o, halt_o;

  irq_sel dut_i (
    .clk_i(clk), .rst_ni(rst_n), .psw_mask_i(psw), .cc_i(cc), .cr6_isc_en_i(cr6),
    .cr14_crw_en_i(cr14), .sync_valid_i(sv), .sync_svc_i(ssvc), .sync_code_i(scode),
    .mchk_push_i(mpush), .mchk_code_i(mcode), .ext_push_i(epush), .ext_code_i(ecode),
    .tod_req_i(tod), .cpt_req_i(cpt), .io_push_i(ipush), .io_isc_i(isc),
    .io_word_i(iword), .take_i(take), .load_psw_i(lpsw), .new_mask_i(nmask),
    .sel_class_o(cls_o), .int_code_o(code_o), .io_word_o(word_o), .old_mask_o(old_o),
    .pend_mchk_o(pm_o), .pend_ext_o(pe_o), .pend_tod_o(pt_o), .pend_cpt_o(pc_o),
    .pend_io_o(pi_o), .irq_o(irq_o), .halted_o(halt_o)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // bench model
  logic [CW-1:0] m_ext [ED];  int m_en = 0;
  logic [CW-1:0] m_mc [MD];   int m_mn = 0;
  logic [IW-1:0] m_io [NI][QD];
  int m_in [NI];
  bit m_tod = 0, m_cpt = 0, m_halt = 0;

  task automatic model_reset();
    m_en = 0; m_mn = 0; m_tod = 0; m_cpt = 0; m_halt = 0;
    for (int i = 0; i < NI; i++) m_in[i] = 0;
  endtask

  function automatic int io_pick();
    for (int i = 0; i < NI; i++) if (m_in[i] > 0 && cr6[i]) return i;
    return -1;
  endfunction

  function automatic logic [2:0] exp_cls();
    if (sv) return ssvc ? 3'd2 : 3'd1;
    if (psw[50] && cr14 && m_mn > 0) return 3'd3;
    if (psw[56] && (m_en > 0 || m_tod || m_cpt)) return 3'd4;
    if (psw[57] && io_pick() >= 0) return 3'd5;
    return 3'd0;
  endfunction

  function automatic logic [CW-1:0] exp_code(input logic [2:0] c);
    case (c)
      3'd1, 3'd2: return scode;
      3'd3: return m_mc[m_mn-1];
      3'd4: return (m_en > 0) ? m_ext[m_en-1] : (m_tod ? 16'h1004 : 16'h1005);
      3'd5: return CW'(io_pick());
      default: return '0;
    endcase
  endfunction

  function automatic bit any_io();
    for (int i = 0; i < NI; i++) if (m_in[i] > 0) return 1;
    return 0;
  endfunction

  task automatic step();
    logic [2:0] ec;
    logic [63:0] eo;
    int pk;
    #2;
    ec = exp_cls();
    chk(cls_o == ec, "R3 class", 64'(cls_o), 64'(ec));
    if (ec == 3'd1 || ec == 3'd2) chk(code_o == exp_code(ec), "R2 code", 64'(code_o), 64'(exp_code(ec)));
    if (ec == 3'd4) chk(code_o == exp_code(ec), "R5 code", 64'(code_o), 64'(exp_code(ec)));
    if (ec == 3'd3) chk(code_o == exp_code(ec), "R6 mchk code", 64'(code_o), 64'(exp_code(ec)));
    if (ec == 3'd5) begin
      pk = io_pick();
      chk(code_o == exp_code(ec), "R7 isc", 64'(code_o), 64'(exp_code(ec)));
      chk(word_o == m_io[pk][m_in[pk]-1], "R7 word", 64'(word_o), 64'(m_io[pk][m_in[pk]-1]));
    end
    chk(pi_o == any_io(), "R8 pend_io", 64'(pi_o), 64'(any_io()));
    chk(irq_o == (m_mn > 0 || m_en > 0 || m_tod || m_cpt || any_io()), "R11 irq",
        64'(irq_o), 64'(m_mn > 0 || m_en > 0 || m_tod || m_cpt || any_io()));
    eo = psw; eo[45:44] = cc;
    chk(old_o == eo, "R9 old mask", old_o, eo);
    @(posedge clk);
    // model update: pop first, then push
    if (take) begin
      case (ec)
        3'd3: m_mn--;
        3'd4: if (m_en > 0) m_en--; else if (m_tod) m_tod = 0; else m_cpt = 0;
        3'd5: begin pk = io_pick(); m_in[pk]--; end
        default: ;
      endcase
    end
    if (tod) m_tod = 1;
    if (cpt) m_cpt = 1;
    if (mpush && m_mn < MD) begin m_mc[m_mn] = mcode; m_mn++; end
    if (epush && m_en < ED) begin m_ext[m_en] = ecode; m_en++; end
    if (ipush && m_in[isc] < QD) begin m_io[isc][m_in[isc]] = iword; m_in[isc]++; end
    if (lpsw) m_halt = nmask[49] & ~nmask[50] & ~nmask[56] & ~nmask[57];
    #1;
    chk(halt_o == m_halt, "R10 halt", 64'(halt_o), 64'(m_halt));
    @(negedge clk);
    mpush = 0; epush = 0; ipush = 0; tod = 0; cpt = 0; take = 0; lpsw = 0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    model_reset();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cls_o == 3'd0 && irq_o == 0 && halt_o == 0 && pi_o == 0 && pm_o == 0 && pe_o == 0,
        "R1 reset", {cls_o, irq_o, halt_o}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R5/R6: stacked external beats timers, LIFO order, overfill dropped
    psw[56] = 1;
    for (int i = 0; i < ED + 1; i++) begin epush = 1; ecode = CW'(16'h0A00 + i); step(); end
    tod = 1; cpt = 1; step();
    for (int i = 0; i < ED + 3; i++) begin take = 1; step(); end
    chk(pe_o == 0 && pt_o == 0 && pc_o == 0, "R6 drained", {pe_o, pt_o, pc_o}, 64'd0);

    // R4: machine check held while channel-report enable is off
    psw[50] = 1; cr14 = 0;
    mpush = 1; mcode = 16'h00AA; step();
    epush = 1; ecode = 16'h0BBB; step();
    take = 1; step();
    chk(pm_o == 1, "R4 mchk kept", 64'(pm_o), 64'd1);
    cr14 = 1; step();
    take = 1; step();

    // R7/R8: masked subclass keeps flag, lowest open subclass wins
    psw = 64'(1) << 57; cr6 = 8'b0010_0000;
    ipush = 1; isc = 3'd2; iword = 32'hCAFE_0002; step();
    ipush = 1; isc = 3'd5; iword = 32'hCAFE_0005; step();
    take = 1; step();
    chk(pi_o == 1, "R8 masked entry keeps flag", 64'(pi_o), 64'd1);
    cr6 = 8'hFF; take = 1; step();

    // R2: synchronous exception overrides
    ipush = 1; isc = 3'd1; iword = 32'h1111; step();
    sv = 1; ssvc = 1; scode = 16'h0042; take = 1; step();
    sv = 0; ssvc = 0; step();

    // R10: halt on wait with all masks off
    lpsw = 1; nmask = 64'(1) << 49; step();
    lpsw = 1; nmask = (64'(1) << 49) | (64'(1) << 56); step();

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      psw = {$urandom(), $urandom()};
      cc = 2'($urandom());
      cr6 = NI'($urandom());
      cr14 = ($urandom() % 4) != 0;
      sv = ($urandom() % 10) == 0;
      ssvc = 1'($urandom());
      scode = CW'($urandom());
      mpush = ($urandom() % 8) == 0; mcode = CW'($urandom());
      epush = ($urandom() % 4) == 0; ecode = CW'($urandom());
      tod = ($urandom() % 10) == 0;
      cpt = ($urandom() % 10) == 0;
      ipush = ($urandom() % 3) == 0; isc = 3'($urandom()); iword = $urandom();
      take = 1'($urandom());
      lpsw = ($urandom() % 6) == 0;
      nmask = {$urandom(), $urandom()};
      step();
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule